// File: doc/BRIEF.md
# Dual Countdown Timer Unit

This block holds two independent down-counters behind a 32-bit register port. Each counter has a reload value register, a read-only current-value register and a control register. The control register picks which of several externally supplied rate strobes advances the counter, whether it runs, whether a control write reloads it, and whether it repeats or fires once.

When a counter expires it sets a pending bit in a shared raw interrupt register. Software clears pending bits through a write-one-to-clear acknowledge register. A mask register gates the pending bits into a masked-status register and onto a single level-sensitive interrupt line. The rate strobes come from outside the block, each one a single-cycle enable pulse at its own rate. A typical use is a periodic system tick on one counter and a one-time delay on the other.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every readable register (byte offsets 0x00, 0x04, 0x08, 0x10, 0x14, 0x18, 0x48, 0x54) reads 0, both counters are stopped and `irq` is low.
- R2: The reload registers (counter 0 at 0x00, counter 1 at 0x10) read back their low CNT_W written bits. The control registers (0x08, 0x18) read back bits [5:0]. The mask register (0x48) reads back bits [1:0]. All upper bits read as 0.
- R3: In a control write, bit 4 (load) copies the reload value into the counter. With bit 4 clear the current value is kept. Bit 3 (run) starts the counter when 1 and stops it when 0. A control write takes priority over a strobe that arrives in the same cycle.
- R4: Control bits [2:0] pick the tick source: code 4, 5, 6 or 7 selects `tick_en[0]`, `[1]`, `[2]` or `[3]`. Every other code selects nothing, and the counter does not advance.
- R5: A running counter decrements by one on each selected strobe. A stopped counter holds its value. The current value reads at 0x04 (counter 0) and 0x14 (counter 1).
- R6: With control bit 5 clear (periodic), a selected strobe that arrives when the value is 1 or 0 is an expiry. On expiry the counter reloads the reload value and keeps running, so expiries come once every reload-value strobes.
- R7: With control bit 5 set (one-shot), an expiry sets the value to 0 and stops the counter. Later strobes change nothing and raise no further expiry.
- R8: Raw pending bit 0 belongs to counter 0 and bit 1 to counter 1. An expiry sets its bit. Writing 0x4C clears the bits written as 1. An expiry in the same cycle as an acknowledge of that bit leaves the bit set.
- R9: 0x54 reads the raw pending bits ANDed with the mask, and `irq` is high exactly when that value is nonzero.
- R10: Accesses whose address has bits [1:0] nonzero, and accesses to unmapped offsets, change nothing on write and read as 0. Offset 0x4C is write-only and reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| tick_en | input | NUM_RATES | One-cycle rate strobes, one per selectable source |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, high while any masked pending bit is set |

## Verification
The bench builds the block with CNT_W = 8, so that the reload values swept fit in a short run and the upper-bit truncation of read-back is visible. The default NUM_RATES = 4 is kept, which lets the bench try every one of the eight select codes against every strobe line. Reload values 1 to 12 are each run through more than two full periods against an arithmetic model of the count. This covers the expiry at value 1 and the back-to-back expiries at reload value 1. Same-cycle collisions are driven on purpose: a control write against a strobe, and an acknowledge against an expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NUM_TMR    = 2;
   localparam int TMR_STRIDE = 'h10;
   localparam int OFF_DIV    = 'h00;
   localparam int OFF_DATA   = 'h04;
   localparam int OFF_CTRL   = 'h08;
   localparam int OFF_MASK   = 'h48;
   localparam int OFF_ACK    = 'h4C;
   localparam int OFF_STAT   = 'h54;
   localparam int CTRL_W     = 6;

   typedef struct packed {
      logic       oneshot;   // bit 5
      logic       load;      // bit 4
      logic       run;       // bit 3
      logic [2:0] csel;      // bits 2:0
   } ctrl_t;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
   parameter int NUM_RATES = 4,
   parameter int SEL_W     = 3,
   parameter int RATE_BASE = 4
) (
   input  logic [SEL_W-1:0]     csel,
   input  logic [NUM_RATES-1:0] tick_en,
   output logic                 tick
);
   if (RATE_BASE + NUM_RATES > (1 << SEL_W)) begin : g_bad_codes
      $error("tmr_tick_sel: rate codes exceed select field");
   end

   logic [NUM_RATES-1:0] hit;
   for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
      assign hit[k] = (csel == SEL_W'(RATE_BASE + k)) & tick_en[k];
   end
   assign tick = |hit;
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_load,
   input  logic             ctl_run,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] reload,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             tc
);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   logic expire_now;
   assign expire_now = running & tick & ~ctl_wr & (cnt <= ONE_C);
   assign tc = expire_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (ctl_wr) begin
         if (ctl_load) cnt <= reload;
         running <= ctl_run;
      end else if (running && tick) begin
         if (expire_now) begin
            if (oneshot) begin
               cnt     <= '0;
               running <= 1'b0;
            end else begin
               cnt <= reload;
            end
         end else begin
            cnt <= cnt - ONE_C;
         end
      end
   end
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg #(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] tc,
   input  logic               ack_wr,
   input  logic [NUM_SRC-1:0] ack_bits,
   input  logic               mask_wr,
   input  logic [NUM_SRC-1:0] mask_wdata,
   output logic [NUM_SRC-1:0] raw_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] masked,
   output logic               irq
);
   logic [NUM_SRC-1:0] clr;
   assign clr = ack_wr ? ack_bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr) | tc;
         if (mask_wr) mask_q <= mask_wdata;
      end
   end

   assign masked = raw_q & mask_q;
   assign irq    = |masked;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
   import tmr_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int NUM_RATES = 4,
   parameter int SEL_W     = 3,
   parameter int RATE_BASE = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_RATES-1:0] tick_en,
   output logic [DATA_W-1:0]    rdata,
   output logic                 irq
);
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("dual_tick_timer: CNT_W must be 2..DATA_W");
   end
   if ((1 << ADDR_W) <= OFF_STAT) begin : g_bad_addr
      $error("dual_tick_timer: ADDR_W too small for register map");
   end
   if (SEL_W != 3 || DATA_W < CTRL_W) begin : g_bad_ctrl
      $error("dual_tick_timer: control layout needs SEL_W 3");
   end

   logic word_ok;
   logic wr_ok;
   assign word_ok = (addr[1:0] == 2'b00);
   assign wr_ok   = wr_en & word_ok;

   ctrl_t wctrl;
   assign wctrl = ctrl_t'(wdata[CTRL_W-1:0]);

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   logic [CNT_W-1:0]   div_q  [NUM_TMR];
   ctrl_t              ctrl_q [NUM_TMR];
   logic [CNT_W-1:0]   cnt_q  [NUM_TMR];
   logic [NUM_TMR-1:0] ctl_wr;
   logic [NUM_TMR-1:0] run;
   logic [NUM_TMR-1:0] tick;
   logic [NUM_TMR-1:0] tc;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      localparam int BASE = i * TMR_STRIDE;
      logic div_wr;
      assign div_wr    = wr_ok & (addr == ADDR_W'(BASE + OFF_DIV));
      assign ctl_wr[i] = wr_ok & (addr == ADDR_W'(BASE + OFF_CTRL));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q[i]  <= '0;
            ctrl_q[i] <= '0;
         end else begin
            if (div_wr)    div_q[i]  <= wdata[CNT_W-1:0];
            if (ctl_wr[i]) ctrl_q[i] <= wctrl;
         end
      end

      tmr_tick_sel #(
         .NUM_RATES (NUM_RATES),
         .SEL_W     (SEL_W),
         .RATE_BASE (RATE_BASE)
      ) u_sel (
         .csel    (ctrl_q[i].csel),
         .tick_en (tick_en),
         .tick    (tick[i])
      );

      tmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_wr   (ctl_wr[i]),
         .ctl_load (wctrl.load),
         .ctl_run  (wctrl.run),
         .oneshot  (ctrl_q[i].oneshot),
         .reload   (div_q[i]),
         .tick     (tick[i]),
         .cnt      (cnt_q[i]),
         .running  (run[i]),
         .tc       (tc[i])
      );
   end

   logic               ack_wr;
   logic               mask_wr;
   logic [NUM_TMR-1:0] raw_q;
   logic [NUM_TMR-1:0] mask_q;
   logic [NUM_TMR-1:0] masked;

   assign ack_wr  = wr_ok & (addr == ADDR_W'(OFF_ACK));
   assign mask_wr = wr_ok & (addr == ADDR_W'(OFF_MASK));

   tmr_irq_agg #(.NUM_SRC(NUM_TMR)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tc         (tc),
      .ack_wr     (ack_wr),
      .ack_bits   (wdata[NUM_TMR-1:0]),
      .mask_wr    (mask_wr),
      .mask_wdata (wdata[NUM_TMR-1:0]),
      .raw_q      (raw_q),
      .mask_q     (mask_q),
      .masked     (masked),
      .irq        (irq)
   );

   always_comb begin
      rdata = '0;
      if (word_ok) begin
         for (int i = 0; i < NUM_TMR; i++) begin
            if (addr == ADDR_W'(i * TMR_STRIDE + OFF_DIV))  rdata = DATA_W'(div_q[i]);
            if (addr == ADDR_W'(i * TMR_STRIDE + OFF_DATA)) rdata = DATA_W'(cnt_q[i]);
            if (addr == ADDR_W'(i * TMR_STRIDE + OFF_CTRL)) rdata = DATA_W'(ctrl_q[i]);
         end
         if (addr == ADDR_W'(OFF_MASK)) rdata = DATA_W'(mask_q);
         if (addr == ADDR_W'(OFF_STAT)) rdata = DATA_W'(masked);
      end
   end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt0,
   input logic [CNT_W-1:0] cnt1,
   input logic [CNT_W-1:0] div0,
   input logic [CNT_W-1:0] div1,
   input logic [1:0]       run,
   input logic [1:0]       tick,
   input logic [1:0]       cwr,
   input logic [1:0]       tc,
   input logic             one0,
   input logic             one1,
   input logic [1:0]       raw,
   input logic [1:0]       mask,
   input logic             ack_wr,
   input logic [1:0]       ack_bits,
   input logic             irq
);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   AST_DEC_ONE_T0: assert property (@(posedge clk) disable iff (!rst_n)
      run[0] && tick[0] && !cwr[0] && cnt0 > ONE_C |=> cnt0 == $past(cnt0) - ONE_C); // R5
   AST_STOP_HOLDS_T0: assert property (@(posedge clk) disable iff (!rst_n)
      !run[0] && !cwr[0] |=> $stable(cnt0)); // R5
   AST_STOP_HOLDS_T1: assert property (@(posedge clk) disable iff (!rst_n)
      !run[1] && !cwr[1] |=> $stable(cnt1)); // R5
   AST_PERIODIC_RELOAD_T0: assert property (@(posedge clk) disable iff (!rst_n)
      tc[0] && !one0 |=> cnt0 == $past(div0) && run[0]); // R6
   AST_PERIODIC_RELOAD_T1: assert property (@(posedge clk) disable iff (!rst_n)
      tc[1] && !one1 |=> cnt1 == $past(div1) && run[1]); // R6
   AST_ONESHOT_STOPS_T0: assert property (@(posedge clk) disable iff (!rst_n)
      tc[0] && one0 |=> !run[0] && cnt0 == '0); // R7
   AST_ONESHOT_STOPS_T1: assert property (@(posedge clk) disable iff (!rst_n)
      tc[1] && one1 |=> !run[1] && cnt1 == '0); // R7
   AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      tc[0] |=> raw[0]); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && ack_bits[1] && !tc[1] |=> !raw[1]); // R8
   AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      mask == 2'b00 |-> !irq); // R9
endmodule

bind dual_tick_timer tmr_chk #(.CNT_W(CNT_W)) u_tmr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt0     (cnt_q[0]),
   .cnt1     (cnt_q[1]),
   .div0     (div_q[0]),
   .div1     (div_q[1]),
   .run      (run),
   .tick     (tick),
   .cwr      (ctl_wr),
   .tc       (tc),
   .one0     (ctrl_q[0].oneshot),
   .one1     (ctrl_q[1].oneshot),
   .raw      (raw_q),
   .mask     (mask_q),
   .ack_wr   (ack_wr),
   .ack_bits (wdata[1:0]),
   .irq      (irq)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 8;
   localparam int NR     = 4;

   localparam logic [7:0] A_DIV0 = 8'h00, A_DAT0 = 8'h04, A_CTL0 = 8'h08;
   localparam logic [7:0] A_DIV1 = 8'h10, A_DAT1 = 8'h14, A_CTL1 = 8'h18;
   localparam logic [7:0] A_MASK = 8'h48, A_ACK = 8'h4C, A_STAT = 8'h54;
   localparam logic [31:0] C_LOAD = 32'h10, C_RUN = 32'h08, C_ONE = 32'h20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [NR-1:0]     tick_en = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dual_tick_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_RATES(NR)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .tick_en(tick_en), .rdata(rdata), .irq(irq));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !done) begin
         failures = failures + 1;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         failures = failures + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [NR-1:0] t);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; tick_en = t;
      @(negedge clk);
      wr_en = 1'b0; tick_en = '0;
   endtask

   task automatic pulse(input logic [NR-1:0] t);
      @(negedge clk);
      tick_en = t;
      @(negedge clk);
      tick_en = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      begin
         logic [7:0] regs [8] = '{A_DIV0, A_DAT0, A_CTL0, A_DIV1, A_DAT1, A_CTL1, A_MASK, A_STAT};
         for (int j = 0; j < 8; j++) begin
            rd(regs[j], v);
            check("R1 reset read", v, 32'h0);
         end
      end
      check("R1 irq after reset", {31'b0, irq}, 32'h0);

      // R2: read-back widths
      wr(A_DIV0, 32'h1234_56A5);
      rd(A_DIV0, v); check("R2 div0 readback", v, 32'h0000_00A5);
      wr(A_CTL1, 32'hFFFF_FFC3);
      rd(A_CTL1, v); check("R2 ctrl1 readback", v, 32'h0000_0003);
      wr(A_CTL1, 32'h0);
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, v); check("R2 mask readback", v, 32'h3);
      wr(A_MASK, 32'h0);

      // R10: misaligned and unmapped
      wr(A_DIV0 + 8'h1, 32'h77);
      rd(A_DIV0, v); check("R10 misaligned write ignored", v, 32'hA5);
      rd(A_DIV0 + 8'h2, v); check("R10 misaligned read zero", v, 32'h0);
      wr(8'h44, 32'hFF);
      rd(8'h44, v); check("R10 unmapped read zero", v, 32'h0);
      rd(A_ACK, v); check("R10 ack reads zero", v, 32'h0);

      // R4: tick source sweep
      wr(A_DIV0, 32'd10);
      for (int code = 0; code < 8; code++) begin
         for (int k = 0; k < NR; k++) begin
            wr(A_CTL0, C_LOAD | C_RUN | code);
            pulse(NR'(1 << k));
            rd(A_DAT0, v);
            check("R4 source select", v, (code == 4 + k) ? 32'd9 : 32'd10);
         end
      end

      // R5/R6: periodic sweep with arithmetic model
      wr(A_MASK, 32'h1);
      for (int d = 1; d <= 12; d++) begin
         int c;
         int ev;
         wr(A_CTL0, 32'h0);
         wr(A_ACK, 32'h3);
         wr(A_DIV0, d);
         wr(A_CTL0, C_LOAD | C_RUN | 32'd4);
         c = d; ev = 0;
         for (int t = 0; t < 2 * d + 1; t++) begin
            pulse(4'b0001);
            if (c <= 1) begin c = d; ev++; end
            else c--;
            rd(A_DAT0, v); check("R5 periodic count", v, c);
            rd(A_STAT, v); check("R6 expiry pending", v, (ev > 0) ? 32'h1 : 32'h0);
         end
      end

      // R3: control write without load keeps count, stop holds
      wr(A_CTL0, 32'h0);
      wr(A_DIV0, 32'd20);
      wr(A_CTL0, C_LOAD | C_RUN | 32'd4);
      pulse(4'b0001); pulse(4'b0001);
      wr(A_DIV0, 32'd50);
      wr(A_CTL0, C_RUN | 32'd4);
      rd(A_DAT0, v); check("R3 no-load keeps count", v, 32'd18);
      wr(A_CTL0, 32'd4);
      pulse(4'b0001);
      rd(A_DAT0, v); check("R3 stopped holds (R5)", v, 32'd18);
      wr(A_CTL0, C_LOAD | 32'd4);
      rd(A_DAT0, v); check("R3 load copies reload", v, 32'd50);
      wr(A_DIV0, 32'd7);
      wr_tick(A_CTL0, C_LOAD | C_RUN | 32'd4, 4'b0001);
      rd(A_DAT0, v); check("R3 write beats strobe", v, 32'd7);
      pulse(4'b0001);
      rd(A_DAT0, v); check("R3 run started", v, 32'd6);

      // R7: one-shot on timer 1, source code 7
      wr(A_CTL0, 32'h0);
      wr(A_MASK, 32'h3);
      wr(A_ACK, 32'h3);
      wr(A_DIV1, 32'd3);
      wr(A_CTL1, C_ONE | C_LOAD | C_RUN | 32'd7);
      for (int t = 1; t <= 3; t++) begin
         pulse(4'b1000);
         rd(A_DAT1, v); check("R7 one-shot count", v, 3 - t);
      end
      rd(A_STAT, v); check("R7 one-shot expiry (R8 bit1)", v, 32'h2);
      check("R9 irq with pending", {31'b0, irq}, 32'h1);
      wr(A_ACK, 32'h2);
      pulse(4'b1000); pulse(4'b1000);
      rd(A_DAT1, v); check("R7 stays at zero", v, 32'h0);
      rd(A_STAT, v); check("R7 no re-expiry", v, 32'h0);
      check("R9 irq low after ack", {31'b0, irq}, 32'h0);

      // R8: collision and selective acknowledge
      wr(A_DIV0, 32'd1);
      wr(A_CTL0, C_LOAD | C_RUN | 32'd5);
      wr_tick(A_ACK, 32'h1, 4'b0010);
      rd(A_STAT, v); check("R8 expiry beats ack", v, 32'h1);
      wr(A_ACK, 32'h2);
      rd(A_STAT, v); check("R8 ack other bit keeps bit0", v, 32'h1);
      wr(A_ACK, 32'h1);
      rd(A_STAT, v); check("R8 ack clears bit0", v, 32'h0);

      // R9: masking
      pulse(4'b0010);
      wr(A_MASK, 32'h0);
      rd(A_STAT, v); check("R9 masked off status", v, 32'h0);
      check("R9 masked off irq", {31'b0, irq}, 32'h0);
      wr(A_MASK, 32'h2);
      check("R9 other mask irq", {31'b0, irq}, 32'h0);
      wr(A_MASK, 32'h1);
      rd(A_STAT, v); check("R9 unmasked status", v, 32'h1);
      check("R9 unmasked irq", {31'b0, irq}, 32'h1);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule